// File: doc/BRIEF.md
# Double-Buffered Register Update Controller

This block sits between a register write port and a synthesis core and keeps two banks of control words apart: a buffer bank that software writes at any time, and an active bank that the core actually uses. Writes never reach the core directly. A transfer copies the whole buffer bank into the active bank in a single system clock. It also loads one word from a bank of profile entries into a separate active profile output. The entry is chosen by a profile select input.

A transfer happens on two triggers: a rising edge on the update input, or any change of value on the profile select input. Both inputs are treated as synchronous to a sync clock that the block derives by dividing the system clock. Both pass through a two-stage sampler clocked at the sync rate. The transfer therefore always lands a fixed number of system clocks after the sync edge that first sees the trigger. The core gets a one-clock transfer pulse that is aligned to the first system clock of each sync period.

Top module: `dbuf_update_ctrl`

## Requirements
- R1: While `mrst` is high and right after it falls, every active register and every buffer register holds its `REG_RST` slice (register i in bits i*DATA_W and up), every profile entry and `act_prof` are zero, `xfer_pulse` is 0 and `sync_clk` is 1.
- R2: `sync_clk` repeats every `SYNC_DIV` system clocks. It is high for the first `SYNC_DIV/2` clocks of each period and low for the rest (default: 1,1,0,0).
- R3: A write with `wr_addr` in 0..NREG-1 (default 0..3) sets buffer register `wr_addr` only. `act_regs` does not change until the next transfer.
- R4: A rising edge on `upd_in` loads every buffer register into `act_regs`. The input is changed in the first clock of a sync high period. The load is seen after the (SYNC_STAGES*SYNC_DIV+1)-th rising clock edge from there (9 by default), and `act_regs` still holds the old values after the edge before it.
- R5: A falling edge on `upd_in` with no profile change causes no transfer and no `xfer_pulse`.
- R6: Any change of `prof_in` causes a transfer with the same latency as R4. `act_prof` then takes profile entry `prof_in`, which is written at address NREG+`prof_in` (default 4..19).
- R7: `xfer_pulse` is high for exactly one system clock per transfer. That clock is the first clock of a sync high period, which is the clock just before the active registers change.
- R8: A write that lands on the same clock edge as a transfer goes into the buffer. The active value loaded by that transfer is the old buffer content, and the written value appears at the next transfer.
- R9: An update rising edge and a profile change seen by the same sample give one transfer and one pulse.
- R10: Writes with `wr_addr` of NREG+2^PROF_W or above (default 20..31) change no buffer register and no profile entry.
- R11: `act_regs` and `act_prof` hold their value on every clock that does not follow a `xfer_pulse` clock.
- R12: Raising `mrst` in mid-operation returns outputs, buffers and profile entries to the values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst | input | 1 | Master reset, active high, synchronous |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | ADDR_W | Write address: buffers, then profile entries |
| wr_data | input | DATA_W | Write data |
| upd_in | input | 1 | Update request, rising edge transfers |
| prof_in | input | PROF_W | Profile select, any change transfers |
| sync_clk | output | 1 | System clock divided by SYNC_DIV |
| xfer_pulse | output | 1 | One-clock transfer strobe |
| act_regs | output | NREG*DATA_W | Active register bank, register i at bits i*DATA_W |
| act_prof | output | DATA_W | Active profile word |

## Verification
A sampler stage that loses or repeats a value would show at the ports as a transfer arriving one sync period early or late, as a missing pulse, or as a second pulse. The bench sees this at the exact clock where the load is due, 9 edges after the trigger by default. A wrong divider phase moves both `sync_clk` and the pulse off the first high clock, and this is visible within one sync period. A buffer or profile entry that takes a wrong write shows as a wrong active word at the next transfer. Each transfer in the bench is preceded by random writes, so such an error is found at the next transfer.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

   // cause of a transfer as seen by the trigger detector
   typedef enum logic [1:0] {
      TRG_NONE = 2'b00,
      TRG_UPD  = 2'b01,
      TRG_PROF = 2'b10,
      TRG_BOTH = 2'b11
   } trig_e;

   // clocks from a trigger change (first sync-high clock) to the visible load
   function automatic int xfer_latency(input int stages, input int div);
      return stages * div + 1;
   endfunction

endpackage

// File: rtl/dbuf_sync_div.sv
module dbuf_sync_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic mrst,
   output logic sync_clk,
   output logic smp_en,
   output logic ph_zero
);
   localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HALF = DIV / 2;

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_nxt;
   logic            sync_q;

   always_comb begin
      if (ph_q == PH_W'(DIV - 1)) ph_nxt = '0;
      else                        ph_nxt = ph_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (mrst) begin
         ph_q   <= '0;
         sync_q <= 1'b1;
      end else begin
         ph_q   <= ph_nxt;
         sync_q <= (ph_nxt < PH_W'(HALF));
      end
   end

   assign sync_clk = sync_q;
   // inputs are sampled on the edge that starts a sync period
   assign smp_en   = (ph_q == PH_W'(DIV - 1));
   assign ph_zero  = (ph_q == '0);
endmodule

// File: rtl/dbuf_trigger.sv
module dbuf_trigger
   import dbuf_pkg::*;
#(
   parameter int PROF_W = 4,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              smp_en,
   input  logic              ph_zero,
   input  logic              upd_in,
   input  logic [PROF_W-1:0] prof_in,
   output logic [PROF_W-1:0] prof_sel,
   output trig_e             cause,
   output logic              xfer
);
   localparam int VW = PROF_W + 1;

   logic [STAGES-1:0][VW-1:0] stg_q;
   logic [VW-1:0]             prev_q;
   logic [VW-1:0]             cur;
   logic                      upd_rise;
   logic                      prof_chg;

   always_ff @(posedge clk) begin
      if (mrst) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else if (smp_en) begin
         stg_q  <= {stg_q[STAGES-2:0], {upd_in, prof_in}};
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign cur      = stg_q[STAGES-1];
   assign upd_rise = cur[PROF_W] & ~prev_q[PROF_W];
   assign prof_chg = (cur[PROF_W-1:0] != prev_q[PROF_W-1:0]);
   assign cause    = trig_e'({prof_chg, upd_rise});
   // the comparison stays true for a whole sync period; gate to phase zero
   assign xfer     = ph_zero && (cause != TRG_NONE);
   assign prof_sel = cur[PROF_W-1:0];
endmodule

// File: rtl/dbuf_reg_bank.sv
module dbuf_reg_bank #(
   parameter int                         NREG    = 4,
   parameter int                         DATA_W  = 32,
   parameter int                         PROF_W  = 4,
   parameter int                         ADDR_W  = 5,
   parameter logic [NREG*DATA_W-1:0]     REG_RST = '0
) (
   input  logic                   clk,
   input  logic                   mrst,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   load,
   input  logic [PROF_W-1:0]      prof_sel,
   output logic [NREG*DATA_W-1:0] buf_flat,
   output logic [NREG*DATA_W-1:0] act_flat,
   output logic [DATA_W-1:0]      act_prof
);
   localparam int NPROF = 1 << PROF_W;

   logic [DATA_W-1:0] prof_q [NPROF];
   logic [DATA_W-1:0] aprof_q;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DATA_W-1:0] buf_q;
      logic [DATA_W-1:0] act_q;
      always_ff @(posedge clk) begin
         if (mrst) begin
            buf_q <= REG_RST[i*DATA_W +: DATA_W];
            act_q <= REG_RST[i*DATA_W +: DATA_W];
         end else begin
            if (wr_en && (wr_addr == ADDR_W'(i))) buf_q <= wr_data;
            if (load)                             act_q <= buf_q;
         end
      end
      assign buf_flat[i*DATA_W +: DATA_W] = buf_q;
      assign act_flat[i*DATA_W +: DATA_W] = act_q;
   end

   for (genvar k = 0; k < NPROF; k++) begin : g_prof
      always_ff @(posedge clk) begin
         if (mrst)                                         prof_q[k] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(NREG + k))) prof_q[k] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (mrst)      aprof_q <= '0;
      else if (load) aprof_q <= prof_q[prof_sel];
   end

   assign act_prof = aprof_q;
endmodule

// File: rtl/dbuf_update_ctrl.sv
module dbuf_update_ctrl
   import dbuf_pkg::*;
#(
   parameter int                     NREG        = 4,
   parameter int                     DATA_W      = 32,
   parameter int                     PROF_W      = 4,
   parameter int                     SYNC_DIV    = 4,
   parameter int                     SYNC_STAGES = 2,
   parameter logic [NREG*DATA_W-1:0] REG_RST     = '0,
   localparam int                    NPROF       = 1 << PROF_W,
   localparam int                    ADDR_W      = $clog2(NREG + NPROF)
) (
   input  logic                   clk,
   input  logic                   mrst,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   upd_in,
   input  logic [PROF_W-1:0]      prof_in,
   output logic                   sync_clk,
   output logic                   xfer_pulse,
   output logic [NREG*DATA_W-1:0] act_regs,
   output logic [DATA_W-1:0]      act_prof
);
   // elaboration-time parameter checks
   if (SYNC_DIV < 2 || (SYNC_DIV % 2) != 0) begin : g_bad_div
      $error("SYNC_DIV must be an even number of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stg
      $error("SYNC_STAGES must be at least 2");
   end
   if (NREG < 1 || DATA_W < 1 || PROF_W < 1) begin : g_bad_size
      $error("NREG, DATA_W and PROF_W must be positive");
   end

   logic                   smp_en;
   logic                   ph_zero;
   logic [PROF_W-1:0]      prof_sel;
   trig_e                  cause;
   logic                   xfer;
   logic [NREG*DATA_W-1:0] buf_regs;

   dbuf_sync_div #(.DIV(SYNC_DIV)) div_i (
      .clk      (clk),
      .mrst     (mrst),
      .sync_clk (sync_clk),
      .smp_en   (smp_en),
      .ph_zero  (ph_zero)
   );

   dbuf_trigger #(.PROF_W(PROF_W), .STAGES(SYNC_STAGES)) trg_i (
      .clk      (clk),
      .mrst     (mrst),
      .smp_en   (smp_en),
      .ph_zero  (ph_zero),
      .upd_in   (upd_in),
      .prof_in  (prof_in),
      .prof_sel (prof_sel),
      .cause    (cause),
      .xfer     (xfer)
   );

   dbuf_reg_bank #(
      .NREG    (NREG),
      .DATA_W  (DATA_W),
      .PROF_W  (PROF_W),
      .ADDR_W  (ADDR_W),
      .REG_RST (REG_RST)
   ) bank_i (
      .clk      (clk),
      .mrst     (mrst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .load     (xfer),
      .prof_sel (prof_sel),
      .buf_flat (buf_regs),
      .act_flat (act_regs),
      .act_prof (act_prof)
   );

   assign xfer_pulse = xfer;
endmodule

// File: rtl/dbuf_update_chk.sv
module dbuf_update_chk #(
   parameter int NREG     = 4,
   parameter int DATA_W   = 32,
   parameter int SYNC_DIV = 4
) (
   input logic                   clk,
   input logic                   mrst,
   input logic                   sync_clk,
   input logic                   xfer_pulse,
   input logic [NREG*DATA_W-1:0] act_regs,
   input logic [DATA_W-1:0]      act_prof,
   input logic [NREG*DATA_W-1:0] buf_regs
);
   logic sc_prev_q;
   int   run_q;

   // length of the current level of sync_clk, counted independently
   always_ff @(posedge clk) begin
      if (mrst) begin
         sc_prev_q <= 1'b1;
         run_q     <= 0;
      end else begin
         sc_prev_q <= sync_clk;
         run_q     <= (sync_clk != sc_prev_q) ? 1 : run_q + 1;
      end
   end

   // R2: each level of the sync clock lasts half a period
   p_sync_level_r2: assert property (@(posedge clk) disable iff (mrst)
      (sync_clk != sc_prev_q) |-> (run_q == SYNC_DIV / 2));

   // R7: the transfer strobe is one clock wide
   p_pulse_width_r7: assert property (@(posedge clk) disable iff (mrst)
      xfer_pulse |=> !xfer_pulse);

   // R7: the strobe sits on the first clock of a sync high period
   p_pulse_phase_r7: assert property (@(posedge clk) disable iff (mrst)
      xfer_pulse |-> (sync_clk && !$past(sync_clk)));

   // R11: active outputs move only right after a strobe
   p_hold_r11: assert property (@(posedge clk) disable iff (mrst)
      !$past(xfer_pulse) |-> ($stable(act_regs) && $stable(act_prof)));

   // R4: a strobe copies the buffer bank as it stood before the edge
   p_load_r4: assert property (@(posedge clk) disable iff (mrst)
      $past(xfer_pulse) |-> (act_regs == $past(buf_regs)));
endmodule

bind dbuf_update_ctrl dbuf_update_chk #(
   .NREG     (NREG),
   .DATA_W   (DATA_W),
   .SYNC_DIV (SYNC_DIV)
) chk_i (
   .clk        (clk),
   .mrst       (mrst),
   .sync_clk   (sync_clk),
   .xfer_pulse (xfer_pulse),
   .act_regs   (act_regs),
   .act_prof   (act_prof),
   .buf_regs   (buf_regs)
);

// File: tb/dbuf_update_ctrl_tb_top.sv
module dbuf_update_ctrl_tb_top;
   localparam int NREG  = 4;
   localparam int DW    = 32;
   localparam int PW    = 4;
   localparam int DIV   = 4;
   localparam int STG   = 2;
   localparam int NPROF = 1 << PW;
   localparam int AW    = $clog2(NREG + NPROF);
   localparam int LAT   = STG * DIV + 1;
   localparam logic [NREG*DW-1:0] RST_VAL =
      {32'hA5A5_0003, 32'h0000_0002, 32'h1234_0001, 32'h0F0F_0000};

   logic          clk = 1'b0;
   logic          mrst = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          upd_in = 1'b0;
   logic [PW-1:0] prof_in = '0;
   logic              sync_clk;
   logic              xfer_pulse;
   logic [NREG*DW-1:0] act_regs;
   logic [DW-1:0]      act_prof;

   always #10 clk = ~clk;

   dbuf_update_ctrl #(
      .NREG(NREG), .DATA_W(DW), .PROF_W(PW), .SYNC_DIV(DIV),
      .SYNC_STAGES(STG), .REG_RST(RST_VAL)
   ) dut_i (
      .clk(clk), .mrst(mrst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .upd_in(upd_in), .prof_in(prof_in),
      .sync_clk(sync_clk), .xfer_pulse(xfer_pulse),
      .act_regs(act_regs), .act_prof(act_prof)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // bench model of the requirements
   logic [DW-1:0] m_buf  [NREG];
   logic [DW-1:0] m_act  [NREG];
   logic [DW-1:0] m_prof [NPROF];
   logic [DW-1:0] m_aprof;
   logic          m_upd;
   logic [PW-1:0] m_psel;

   task automatic check(input bit ok, input string tag,
                        input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic check_act(input string tag);
      for (int i = 0; i < NREG; i++)
         check(act_regs[i*DW +: DW] === m_act[i], tag, act_regs[i*DW +: DW], m_act[i]);
      check(act_prof === m_aprof, tag, act_prof, m_aprof);
   endtask

   task automatic model_reset();
      for (int i = 0; i < NREG; i++) begin
         m_buf[i] = RST_VAL[i*DW +: DW];
         m_act[i] = RST_VAL[i*DW +: DW];
      end
      for (int k = 0; k < NPROF; k++) m_prof[k] = '0;
      m_aprof = '0;
      m_upd   = 1'b0;
      m_psel  = '0;
   endtask

   function automatic void model_write(input int addr, input logic [DW-1:0] d);
      if (addr < NREG)              m_buf[addr] = d;
      else if (addr < NREG + NPROF) m_prof[addr - NREG] = d;
   endfunction

   task automatic do_write(input int addr, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(addr, d);
   endtask

   // return at the negedge inside the first clock of a sync high period
   task automatic align();
      logic p;
      p = sync_clk;
      forever begin
         @(negedge clk);
         if (sync_clk && !p) break;
         p = sync_clk;
      end
   endtask

   task automatic trigger(input logic u, input logic [PW-1:0] p, input bit cw,
                          input int cw_addr, input logic [DW-1:0] cw_data,
                          input string tag);
      bit exp_x;
      int pulses;
      align();
      exp_x   = (u && !m_upd) || (p != m_psel);
      upd_in  = u;
      prof_in = p;
      pulses  = 0;
      for (int c = 1; c < LAT; c++) begin
         @(negedge clk);
         if (xfer_pulse) pulses++;
      end
      check(xfer_pulse == exp_x, {tag, " R7 strobe position"}, DW'(xfer_pulse), DW'(exp_x));
      check_act({tag, " R11 old value before load"});
      if (cw) begin
         wr_en = 1'b1; wr_addr = AW'(cw_addr); wr_data = cw_data;
      end
      if (exp_x) begin
         for (int i = 0; i < NREG; i++) m_act[i] = m_buf[i];
         m_aprof = m_prof[p];
      end
      if (cw) model_write(cw_addr, cw_data);
      @(negedge clk);
      wr_en = 1'b0;
      if (xfer_pulse) pulses++;
      check_act({tag, " load at latency"});
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (xfer_pulse) pulses++;
      end
      check(pulses == int'(exp_x), {tag, " R7 R9 pulse count"}, DW'(pulses), DW'(exp_x));
      m_upd  = u;
      m_psel = p;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      // R1: reset state
      repeat (3) @(negedge clk);
      check(sync_clk === 1'b1, "R1 sync_clk in reset", DW'(sync_clk), 1);
      check(xfer_pulse === 1'b0, "R1 xfer in reset", DW'(xfer_pulse), 0);
      check_act("R1 reset values");
      mrst = 1'b0;
      @(negedge clk);
      check_act("R1 after release");

      // R2: divider pattern
      align();
      for (int k = 1; k < 2 * DIV; k++) begin
         @(negedge clk);
         check(sync_clk === ((k % DIV) < DIV / 2), "R2 sync_clk pattern",
               DW'(sync_clk), DW'((k % DIV) < DIV / 2));
      end

      // R1: buffers hold defaults; a transfer shows them
      trigger(1'b1, '0, 1'b0, 0, '0, "R1 R4 buffer defaults");
      trigger(1'b0, '0, 1'b0, 0, '0, "R5 falling edge");

      // R3: writes stay in the buffer
      do_write(0, 32'hDEAD_0000);
      do_write(3, 32'hBEEF_0003);
      do_write(NREG + 5, 32'h5555_AAAA);
      check_act("R3 R11 write does not reach active");
      trigger(1'b1, '0, 1'b0, 0, '0, "R4 update rise");

      // R6: profile change picks entry 5
      trigger(1'b1, 4'd5, 1'b0, 0, '0, "R6 profile change");
      do_write(NREG + 15, 32'h0F0F_F0F0);
      trigger(1'b1, 4'd15, 1'b0, 0, '0, "R6 profile top entry");

      // R8: write on the transfer edge
      trigger(1'b0, 4'd15, 1'b0, 0, '0, "R5 fall again");
      trigger(1'b1, 4'd15, 1'b1, 1, 32'h0101_0101, "R8 coincident write");
      trigger(1'b1, 4'd3, 1'b0, 0, '0, "R8 write seen next");

      // R9: both triggers together
      trigger(1'b0, 4'd3, 1'b0, 0, '0, "R5 fall");
      do_write(2, 32'h2222_2222);
      trigger(1'b1, 4'd9, 1'b0, 0, '0, "R9 both triggers");

      // R10: addresses past the profile bank
      do_write(NREG + NPROF, 32'hFFFF_FFFF);
      do_write((1 << AW) - 1, 32'hEEEE_EEEE);
      check_act("R10 R11 no effect at once");
      trigger(1'b1, 4'd0, 1'b0, 0, '0, "R10 out of range ignored");
      trigger(1'b1, 4'd4, 1'b0, 0, '0, "R10 profile view");

      // random mix of writes and triggers
      for (int it = 0; it < 40; it++) begin
         int nw;
         int mode;
         logic u;
         logic [PW-1:0] p;
         nw = int'($urandom_range(0, 3));
         for (int w = 0; w < nw; w++)
            do_write(int'($urandom_range(0, (1 << AW) - 1)), $urandom);
         mode = int'($urandom_range(0, 3));
         u = m_upd;
         p = m_psel;
         if (mode == 0 || mode == 2) u = !m_upd;
         if (mode == 1 || mode == 2) p = PW'($urandom);
         trigger(u, p, ($urandom_range(0, 3) == 0),
                 int'($urandom_range(0, NREG + NPROF - 1)), $urandom,
                 "R4 R6 R8 random");
      end

      // R12: reset in mid-operation
      do_write(1, 32'h7777_7777);
      @(negedge clk);
      mrst = 1'b1; upd_in = 1'b0; prof_in = '0;
      repeat (3) @(negedge clk);
      model_reset();
      check(sync_clk === 1'b1, "R12 sync_clk reset", DW'(sync_clk), 1);
      check_act("R12 outputs to defaults");
      mrst = 1'b0;
      trigger(1'b1, '0, 1'b0, 0, '0, "R12 buffers to defaults");
      trigger(1'b1, 4'd7, 1'b0, 0, '0, "R12 profiles to zero");

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         fails++;
         $display("FAIL watchdog R1-12 all got=timeout exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule